// File: doc/BRIEF.md
# Daisy-Chained Poll Responder for a Serial Card

This block is the bus-side control of one serial communications card on a shared parallel bus. The cards on the bus are linked in a chain by a poll line. The block watches the status outputs of the card's UART and its modem and line controls: data ready, transmit holding register empty, clear to send, break, and the receiver and transmitter enables. From these it keeps registered receive and transmit ready flags. A card with no work passes the incoming poll straight on to the next card. A card with work keeps the poll and identifies itself on the address lines. It drives its strapped card address there, together with a direction bit.

When the CPU answers a receive claim with a read strobe, the block puts the received character on the data lines. One clock later it pulses the UART's data-ready clear input. When data ready then falls, the card deselects itself and pulses a load strobe for the error-status latch. Receive always wins over transmit on the same poll, because the poll reaches the transmit gate only after it has passed the receive gate. All UART and modem inputs pass through a parameterised synchronizer. The bus lines model open-collector drivers, so an undriven line reads as 1.

Top module: `poll_responder`

## Requirements
- R1: When neither the receive nor the transmit ready flag is set, poll_out equals poll_in in the same cycle. abus and dbus then read all ones.
- R2: The receive ready flag becomes visible SYNC_STAGES+1 clock edges after uart_dr and rx_enable are both high. While the flag is set, poll_out stays 0 whatever poll_in is.
- R3: While poll_in is 1 and the receive ready flag is set, abus[ADDR_W:1] carries the bitwise inverse of CARD_ADDR and abus[0] is 1. abus returns to all ones when poll_in is 0.
- R4: The receive select flag is set on a clock edge where the card holds the poll in receive mode. dbus carries the bitwise inverse of rx_char only while receive select and cpu_rd_strobe are both 1; otherwise dbus is all ones.
- R5: uart_dr_clr is 1 in the cycle after each cycle in which the character is gated onto dbus, and 0 otherwise.
- R6: Once uart_dr falls, both receive flags clear SYNC_STAGES+1 edges later, and poll passing resumes on that edge. err_latch_load is 1 for exactly that one cycle.
- R7: When rx_enable is low (after synchronization), both receive flags are forced clear and the poll passes.
- R8: The transmit ready flag is set only when all four synchronized conditions hold: uart_thre is 1, modem_cts is 1, tx_enable is 1 and line_break is 0. It becomes visible SYNC_STAGES+1 edges after the last of them is met.
- R9: The transmit ready flag is cleared when tx_enable goes low or line_break goes high, SYNC_STAGES+1 edges later.
- R10: When both ready flags are set, a poll is claimed in receive mode (abus[0]=1). A transmit-only claim drives abus[0]=0 with the inverted address on abus[ADDR_W:1].
- R11: A synchronous active-high reset clears all flags, the synchronizers and the strobe pipeline. After reset, poll_out equals poll_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_in | input | 1 | Poll from the previous card in the chain |
| poll_out | output | 1 | Poll passed to the next card |
| uart_dr | input | 1 | UART received-data-ready status |
| uart_thre | input | 1 | UART transmit holding register empty |
| modem_cts | input | 1 | Clear to send from the modem |
| line_break | input | 1 | Break condition active |
| rx_enable | input | 1 | Receiver on (low forces receive not ready) |
| tx_enable | input | 1 | Transmitter on |
| cpu_rd_strobe | input | 1 | CPU input strobe for the received character |
| rx_char | input | DATA_W | Character held in the UART receive register |
| uart_dr_clr | output | 1 | Pulse to the UART data-ready reset input |
| err_latch_load | output | 1 | Load strobe for the error-status latch |
| abus | output | ADDR_W+1 | Address bus: [ADDR_W:1] inverted card address, [0] direction |
| dbus | output | DATA_W | Data bus, inverted character when driven, all ones otherwise |

## Verification
The bench builds the block with SYNC_STAGES=2, CARD_ADDR=4'hA, ADDR_W=4 and DATA_W=8. This makes the three-edge input latency observable: the bench checks the poll just before and just after a flag changes. The strap value 4'hA has mixed bit values, so its inverse on abus exposes swapped or uninverted address bits. The receive/transmit encodings 5'h0B and 5'h0A differ only in the direction bit, so a priority error shows up directly.

// File: rtl/poll_pkg.sv
package poll_pkg;
  // order of the synchronized status vector
  localparam int ST_DR    = 0;
  localparam int ST_THRE  = 1;
  localparam int ST_CTS   = 2;
  localparam int ST_BRK   = 3;
  localparam int ST_RXON  = 4;
  localparam int ST_TXON  = 5;
  localparam int ST_W     = 6;

  typedef struct packed {
    logic tx_on;
    logic rx_on;
    logic brk;
    logic cts;
    logic thre;
    logic dr;
  } uart_stat_t;

  function automatic uart_stat_t unpack_stat(input logic [ST_W-1:0] v);
    uart_stat_t s;
    s.dr    = v[ST_DR];
    s.thre  = v[ST_THRE];
    s.cts   = v[ST_CTS];
    s.brk   = v[ST_BRK];
    s.rx_on = v[ST_RXON];
    s.tx_on = v[ST_TXON];
    return s;
  endfunction
endpackage

// File: rtl/poll_sync.sv
module poll_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stage [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= '0;
          else     stage[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= '0;
          else     stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign q = stage[LAST];
endmodule

// File: rtl/poll_rx_ctrl.sv
module poll_rx_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic dr_s,
  input  logic rx_on_s,
  input  logic rx_claim,
  input  logic rd_strobe,
  output logic rx_rdy,
  output logic rx_sel,
  output logic rd_gate,
  output logic dr_clr,
  output logic err_load
);
  logic rx_live;
  logic rx_sel_nx;

  assign rx_live   = dr_s & rx_on_s;
  assign rx_sel_nx = rx_live & (rx_sel | rx_claim);
  assign rd_gate   = rx_sel & rd_strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_rdy   <= 1'b0;
      rx_sel   <= 1'b0;
      dr_clr   <= 1'b0;
      err_load <= 1'b0;
    end else begin
      rx_rdy   <= rx_live;
      rx_sel   <= rx_sel_nx;
      dr_clr   <= rd_gate;
      err_load <= rx_sel & ~rx_sel_nx;
    end
  end

  AST_SEL_FROM_CLAIM: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_sel) |-> $past(rx_claim)); // R4
  AST_CLR_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    dr_clr |-> $past(rx_sel && rd_strobe)); // R5
  AST_LOAD_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    err_load |-> (!rx_sel && $past(rx_sel))); // R6
  AST_RXOFF_FORCES: assert property (@(posedge clk) disable iff (rst)
    !rx_on_s |=> (!rx_rdy && !rx_sel)); // R7
endmodule

// File: rtl/poll_tx_ctrl.sv
module poll_tx_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic thre_s,
  input  logic cts_s,
  input  logic tx_on_s,
  input  logic brk_s,
  output logic tx_rdy
);
  logic tx_ok;

  assign tx_ok = thre_s & cts_s & tx_on_s & ~brk_s;

  always_ff @(posedge clk) begin
    if (rst) tx_rdy <= 1'b0;
    else     tx_rdy <= tx_ok;
  end

  AST_TX_DROP: assert property (@(posedge clk) disable iff (rst)
    (!tx_on_s || brk_s) |=> !tx_rdy); // R9
  AST_TX_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_rdy) |-> $past(thre_s && cts_s && tx_on_s && !brk_s)); // R8
endmodule

// File: rtl/poll_bus_drive.sv
module poll_bus_drive #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poll_in,
  input  logic              rx_rdy,
  input  logic              tx_rdy,
  input  logic              rd_gate,
  input  logic [ADDR_W-1:0] card_addr,
  input  logic [DATA_W-1:0] rx_char,
  output logic              rx_claim,
  output logic              poll_out,
  output logic [ADDR_W:0]   abus,
  output logic [DATA_W-1:0] dbus
);
  logic poll_mid;
  logic tx_claim;

  // receive gate first, transmit gate only sees what receive lets through
  assign rx_claim = poll_in & rx_rdy;
  assign poll_mid = poll_in & ~rx_rdy;
  assign tx_claim = poll_mid & tx_rdy;
  assign poll_out = poll_mid & ~tx_rdy;

  always_comb begin
    abus = '1;
    if (rx_claim) begin
      abus[ADDR_W:1] = ~card_addr;
      abus[0]        = 1'b1;
    end else if (tx_claim) begin
      abus[ADDR_W:1] = ~card_addr;
      abus[0]        = 1'b0;
    end
  end

  assign dbus = rd_gate ? ~rx_char : '1;

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0({poll_out, rx_claim, tx_claim})); // R10
endmodule

// File: rtl/poll_responder.sv
module poll_responder #(
  parameter int              ADDR_W      = 4,
  parameter int              DATA_W      = 8,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CARD_ADDR = 4'hA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poll_in,
  output logic              poll_out,
  input  logic              uart_dr,
  input  logic              uart_thre,
  input  logic              modem_cts,
  input  logic              line_break,
  input  logic              rx_enable,
  input  logic              tx_enable,
  input  logic              cpu_rd_strobe,
  input  logic [DATA_W-1:0] rx_char,
  output logic              uart_dr_clr,
  output logic              err_latch_load,
  output logic [ADDR_W:0]   abus,
  output logic [DATA_W-1:0] dbus
);
  import poll_pkg::*;

  logic [ST_W-1:0] raw_st;
  logic [ST_W-1:0] sync_st;
  uart_stat_t      st;
  logic rx_rdy, rx_sel, rd_gate, rx_claim, tx_rdy;

  always_comb begin
    raw_st           = '0;
    raw_st[ST_DR]    = uart_dr;
    raw_st[ST_THRE]  = uart_thre;
    raw_st[ST_CTS]   = modem_cts;
    raw_st[ST_BRK]   = line_break;
    raw_st[ST_RXON]  = rx_enable;
    raw_st[ST_TXON]  = tx_enable;
  end

  poll_sync #(.W(ST_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_st), .q(sync_st)
  );

  assign st = unpack_stat(sync_st);

  poll_rx_ctrl u_rx (
    .clk(clk), .rst(rst),
    .dr_s(st.dr), .rx_on_s(st.rx_on),
    .rx_claim(rx_claim), .rd_strobe(cpu_rd_strobe),
    .rx_rdy(rx_rdy), .rx_sel(rx_sel), .rd_gate(rd_gate),
    .dr_clr(uart_dr_clr), .err_load(err_latch_load)
  );

  poll_tx_ctrl u_tx (
    .clk(clk), .rst(rst),
    .thre_s(st.thre), .cts_s(st.cts), .tx_on_s(st.tx_on), .brk_s(st.brk),
    .tx_rdy(tx_rdy)
  );

  poll_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst),
    .poll_in(poll_in), .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .rd_gate(rd_gate),
    .card_addr(CARD_ADDR), .rx_char(rx_char),
    .rx_claim(rx_claim), .poll_out(poll_out), .abus(abus), .dbus(dbus)
  );

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (!rx_rdy && !tx_rdy) |-> (poll_out == poll_in && abus == '1)); // R1
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!rx_rdy && !rx_sel && !tx_rdy && !uart_dr_clr)); // R11
endmodule

// File: tb/test_poll_responder.sv
module test_poll_responder;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam logic [AW-1:0] ADDR = 4'hA;
  localparam logic [AW:0] AB_IDLE = '1;
  localparam logic [AW:0] AB_RX = {~ADDR, 1'b1};
  localparam logic [AW:0] AB_TX = {~ADDR, 1'b0};

  logic clk = 0, rst = 1;
  logic poll_in = 0, uart_dr = 0, uart_thre = 0, modem_cts = 0, line_break = 0;
  logic rx_enable = 1, tx_enable = 1, cpu_rd_strobe = 0;
  logic [DW-1:0] rx_char = '0;
  logic poll_out, uart_dr_clr, err_latch_load;
  logic [AW:0] abus;
  logic [DW-1:0] dbus;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  poll_responder #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2), .CARD_ADDR(ADDR)) i_poll_responder (
    .clk(clk), .rst(rst), .poll_in(poll_in), .poll_out(poll_out),
    .uart_dr(uart_dr), .uart_thre(uart_thre), .modem_cts(modem_cts),
    .line_break(line_break), .rx_enable(rx_enable), .tx_enable(tx_enable),
    .cpu_rd_strobe(cpu_rd_strobe), .rx_char(rx_char),
    .uart_dr_clr(uart_dr_clr), .err_latch_load(err_latch_load),
    .abus(abus), .dbus(dbus)
  );

  typedef struct {
    string       req;
    int          sel;
    logic [15:0] exp;
  } item_t;

  item_t sbq[$];
  event  sample_ev;

  function automatic logic [15:0] observe(int sel);
    case (sel)
      0: return 16'(poll_out);
      1: return 16'(abus);
      2: return 16'(dbus);
      3: return 16'(uart_dr_clr);
      default: return 16'(err_latch_load);
    endcase
  endfunction

  // monitor: pops expectations and compares with the port values
  initial begin
    forever begin
      @(sample_ev);
      while (sbq.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sbq.pop_front();
        act = observe(it.sel);
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  // driver-side: push expected item, wake monitor
  task automatic expect_out(string req, int sel, logic [15:0] exp);
    sbq.push_back('{req, sel, exp});
    ->sample_ev;
    #1;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    poll_in = 1;
    tick(3);
    expect_out("R11 poll follows in reset", 0, 1);
    expect_out("R11 abus idle in reset", 1, 16'(AB_IDLE));
    expect_out("R11 no clr in reset", 3, 0);
    rst = 0;
    tick(1);
    // R1 idle pass-through
    poll_in = 0; #1;
    expect_out("R1 pass low", 0, 0);
    poll_in = 1; #1;
    expect_out("R1 pass high", 0, 1);
    expect_out("R1 abus idle", 1, 16'(AB_IDLE));
    expect_out("R1 dbus idle", 2, 16'hFF);

    // R2 / R3 receive ready and claim
    uart_dr = 1;
    tick(2);
    expect_out("R2 not yet ready after 2 edges", 0, 1);
    tick(1);
    expect_out("R2 poll blocked", 0, 0);
    expect_out("R3 rx address", 1, 16'(AB_RX));
    poll_in = 0; #1;
    expect_out("R3 abus idle without poll", 1, 16'(AB_IDLE));
    // R4 strobe before capture does nothing
    rx_char = 8'h3C; cpu_rd_strobe = 1; #1;
    expect_out("R4 no data before capture", 2, 16'hFF);
    cpu_rd_strobe = 0;
    tick(1);
    expect_out("R5 no clr without gated read", 3, 0);
    poll_in = 1;
    tick(1);
    expect_out("R4 no data without strobe", 2, 16'hFF);
    cpu_rd_strobe = 1; #1;
    expect_out("R4 data on bus", 2, 16'h00C3);
    expect_out("R5 clr not yet", 3, 0);
    tick(1);
    expect_out("R5 clr one clock later", 3, 1);
    cpu_rd_strobe = 0; uart_dr = 0;
    tick(1);
    expect_out("R5 clr ends", 3, 0);
    expect_out("R4 data removed without strobe", 2, 16'hFF);
    tick(1);
    expect_out("R6 still selected", 0, 0);
    expect_out("R6 no load yet", 4, 0);
    tick(1);
    expect_out("R6 poll released", 0, 1);
    expect_out("R6 error latch load", 4, 1);
    expect_out("R6 abus idle", 1, 16'(AB_IDLE));
    tick(1);
    expect_out("R6 load is one cycle", 4, 0);

    // R7 receiver off
    uart_dr = 1;
    tick(3);
    expect_out("R7 claimed before off", 0, 0);
    rx_enable = 0;
    tick(2);
    expect_out("R7 still claimed in sync", 0, 0);
    tick(1);
    expect_out("R7 forced not ready", 0, 1);
    uart_dr = 0; rx_enable = 1;
    tick(4);

    // R8 transmit needs all four
    uart_thre = 1; tx_enable = 1; line_break = 0; modem_cts = 0;
    tick(5);
    expect_out("R8 no cts no claim", 0, 1);
    modem_cts = 1;
    tick(2);
    expect_out("R8 not yet", 0, 1);
    tick(1);
    expect_out("R8 tx claim", 0, 0);
    expect_out("R10 tx address bit0 low", 1, 16'(AB_TX));

    // R9 break and tx_enable clear
    line_break = 1;
    tick(3);
    expect_out("R9 break clears", 0, 1);
    line_break = 0;
    tick(3);
    expect_out("R9 ready again", 0, 0);
    tx_enable = 0;
    tick(3);
    expect_out("R9 tx off clears", 0, 1);
    tx_enable = 1;
    tick(3);

    // R10 priority with both ready
    uart_dr = 1;
    tick(3);
    expect_out("R10 rx wins", 1, 16'(AB_RX));
    expect_out("R10 poll held", 0, 0);

    // R11 reset mid-operation
    rst = 1;
    tick(1);
    expect_out("R11 pass after reset", 0, 1);
    expect_out("R11 abus idle after reset", 1, 16'(AB_IDLE));
    rst = 0;

    done = 1;
    tick(1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule